// File: doc/BRIEF.md
# Programmable Raster Sync Generator

This block generates the timing for a raster display. A horizontal counter counts clock cycles within a line, and a line counter counts lines within a frame. Both totals come from programmable 12-bit values. Every pulse is set by a pair of 12-bit counts: it turns on when its counter reaches the first count and turns off when the counter reaches the second. Horizontal pulses use clock positions within a line. Vertical pulses use line positions within a frame. All state, including every output, updates on the falling edge of the clock.

An 8-bit mode word controls the generator:

| Bit | Function when set |
|-----|-------------------|
| 0 | Run: the counters advance |
| 1 | Composite: combined sync and blanking |
| 2 | Interlace: field tracking |
| 3 | Equalisation and serration |
| 4 | Invert horizontal sync output |
| 5 | Invert horizontal blanking output |
| 6 | Invert vertical/composite sync output |
| 7 | Invert vertical/composite blanking output |

In separate mode, the two vertical outputs carry vertical sync and vertical blanking. In composite mode, they carry combined sync and combined blanking, and the combined sync can include double-rate equalising pulses and serration notches. A field output shows which field of an interlaced frame is being scanned.

An asynchronous active-high clear returns the counters to the origin and drives all pulse outputs low. The generator then stays stopped until the run bit is set.

Top module: `raster_timing_gen`

## Requirements
- R1: While run (mode bit 0) is 1, each falling clock edge moves the position forward by one clock. The clock counter runs from 0 to h_total-1 and then wraps to 0, which moves the line counter forward. The line counter runs from 0 to v_total-1 and then wraps to 0.
- R2: The raw horizontal sync is active when the clock count c satisfies one of two conditions. If start <= end, the condition is start <= c < end. If start > end, the condition is c >= start or c < end, so the pulse wraps across the end of the line. When start equals end, the pulse is never active. The same rule applies to horizontal blanking, using its own counts.
- R3: Vertical sync and vertical blanking follow the R2 window rule, applied to the line count. When composite (mode bit 1) is 0, vcsync_o carries vertical sync and vcblank_o carries vertical blanking. In this mode the equalisation bit has no effect.
- R4: Each output is the raw signal XORed with its polarity bit. Mode bit 4 inverts hsync_o, bit 5 inverts hblank_o, bit 6 inverts vcsync_o and bit 7 inverts vcblank_o.
- R5: In composite mode with equalisation (mode bit 3) at 0, the raw vcsync_o is horizontal sync XOR vertical sync. In composite mode, the raw vcblank_o is horizontal blanking OR vertical blanking.
- R6: In composite mode with equalisation at 1, during lines where vertical sync is active, the raw vcsync_o is 1 except inside two serration windows. The first window is [ser_start, ser_end). The second is the same window shifted by half_line.
- R7: In composite mode with equalisation at 1, on lines inside the equalising-line window [eqz_start, eqz_end) that are outside vertical sync, the raw vcsync_o is 1 only inside two windows. The first is [eq_start, eq_end). The second is the same window shifted by half_line. On all other lines, vcsync_o follows horizontal sync. Shifted counts wrap modulo 4096.
- R8: With interlace (mode bit 2) at 1, odd_o toggles at every frame wrap. It is 1 in the field after clear. With interlace at 0, odd_o is 1 after each falling edge.
- R9: A high level on clr immediately sets all four pulse outputs low, sets odd_o high and sets both counters to 0. This happens without waiting for a clock edge.
- R10: While run is 0, the counters hold their values at each edge. The outputs then reflect the held position with the current mode bits applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; state changes on its falling edge |
| clr | input | 1 | Asynchronous clear, active high |
| mode_word | input | 8 | Run, composite, interlace, equalisation and polarity bits |
| h_total | input | 12 | Clocks per line |
| v_total | input | 12 | Lines per frame |
| half_line | input | 12 | Offset, in clocks, of the second equalising or serration pulse in a line |
| hs_start | input | 12 | Horizontal sync start count |
| hs_end | input | 12 | Horizontal sync end count |
| hb_start | input | 12 | Horizontal blanking start count |
| hb_end | input | 12 | Horizontal blanking end count |
| vs_start | input | 12 | Vertical sync start line |
| vs_end | input | 12 | Vertical sync end line |
| vb_start | input | 12 | Vertical blanking start line |
| vb_end | input | 12 | Vertical blanking end line |
| eq_start | input | 12 | Equalising pulse start count |
| eq_end | input | 12 | Equalising pulse end count |
| ser_start | input | 12 | Serration notch start count |
| ser_end | input | 12 | Serration notch end count |
| eqz_start | input | 12 | First line of the equalising interval |
| eqz_end | input | 12 | Line that ends the equalising interval |
| hsync_o | output | 1 | Horizontal sync |
| hblank_o | output | 1 | Horizontal blanking |
| vcsync_o | output | 1 | Vertical or composite sync |
| vcblank_o | output | 1 | Vertical or composite blanking |
| odd_o | output | 1 | Field indicator: high for the odd field |

## Verification
If the clock counter goes wrong, hsync_o and hblank_o move away from their expected clock positions within one line. A line counter that slips shows up on the vertical outputs within one line. The composite selection produces distinctive double-rate pulses and notches, so any error in it is visible within the first vertical interval. A field bit that fails to toggle shows on odd_o at the first frame wrap.

// File: rtl/rtg_pkg.sv
package rtg_pkg;
    localparam int unsigned CW     = 12;
    localparam int unsigned MODE_W = 8;

    localparam int unsigned M_RUN   = 0;
    localparam int unsigned M_COMP  = 1;
    localparam int unsigned M_ILACE = 2;
    localparam int unsigned M_EQ    = 3;
    localparam int unsigned M_HSINV = 4;
    localparam int unsigned M_HBINV = 5;
    localparam int unsigned M_CSINV = 6;
    localparam int unsigned M_CBINV = 7;

    typedef logic [CW-1:0] cnt_t;

    typedef struct packed {
        cnt_t hcnt;
        cnt_t vcnt;
        logic odd;
        logic hs;
        logic hb;
        logic vcs;
        logic vcb;
    } rtg_state_t;
endpackage

// File: rtl/rtg_window.sv
module rtg_window #(
    parameter int unsigned W = 12
) (
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] lo,
    input  logic [W-1:0] hi,
    output logic         act
);
    always_comb begin
        if (lo <= hi) act = (cnt >= lo) && (cnt < hi);
        else          act = (cnt >= lo) || (cnt < hi);
    end
endmodule

// File: rtl/rtg_counters.sv
module rtg_counters #(
    parameter int unsigned W = 12
) (
    input  logic         run,
    input  logic         interlace,
    input  logic [W-1:0] hcnt,
    input  logic [W-1:0] vcnt,
    input  logic         odd,
    input  logic [W-1:0] h_total,
    input  logic [W-1:0] v_total,
    output logic [W-1:0] hcnt_n,
    output logic [W-1:0] vcnt_n,
    output logic         odd_n
);
    localparam int unsigned XW = W + 1;
    logic h_wrap, v_wrap;

    always_comb begin
        h_wrap = ({1'b0, hcnt} + XW'(1)) >= {1'b0, h_total};
        v_wrap = ({1'b0, vcnt} + XW'(1)) >= {1'b0, v_total};
        hcnt_n = hcnt;
        vcnt_n = vcnt;
        odd_n  = odd;
        if (run) begin
            hcnt_n = h_wrap ? '0 : hcnt + W'(1);
            if (h_wrap) begin
                vcnt_n = v_wrap ? '0 : vcnt + W'(1);
                if (v_wrap) odd_n = ~odd;
            end
        end
        if (!interlace) odd_n = 1'b1;
    end
endmodule

// File: rtl/rtg_compose.sv
module rtg_compose #(
    parameter int unsigned W = 12
) (
    input  logic [W-1:0] hcnt,
    input  logic [W-1:0] vcnt,
    input  logic [W-1:0] half,
    input  logic [W-1:0] eq_lo,
    input  logic [W-1:0] eq_hi,
    input  logic [W-1:0] ser_lo,
    input  logic [W-1:0] ser_hi,
    input  logic [W-1:0] eqz_lo,
    input  logic [W-1:0] eqz_hi,
    input  logic         hs,
    input  logic         hb,
    input  logic         vs,
    input  logic         vb,
    input  logic         composite,
    input  logic         eq_en,
    output logic         cs,
    output logic         cb
);
    localparam int unsigned NPH = 2;
    logic [NPH-1:0] eq_hit;
    logic [NPH-1:0] ser_hit;
    logic           eqz_hit;

    for (genvar ph = 0; ph < NPH; ph++) begin : g_phase
        logic [W-1:0] off, eql, eqh, sel, seh;
        assign off = (ph == 0) ? '0 : half;
        assign eql = eq_lo + off;
        assign eqh = eq_hi + off;
        assign sel = ser_lo + off;
        assign seh = ser_hi + off;
        rtg_window #(.W(W)) u_eq  (.cnt(hcnt), .lo(eql), .hi(eqh), .act(eq_hit[ph]));
        rtg_window #(.W(W)) u_ser (.cnt(hcnt), .lo(sel), .hi(seh), .act(ser_hit[ph]));
    end

    rtg_window #(.W(W)) u_eqz (.cnt(vcnt), .lo(eqz_lo), .hi(eqz_hi), .act(eqz_hit));

    always_comb begin
        if (!composite) begin
            cs = vs;
            cb = vb;
        end else begin
            cb = hb | vb;
            if (!eq_en)       cs = hs ^ vs;
            else if (vs)      cs = ~(|ser_hit);
            else if (eqz_hit) cs = |eq_hit;
            else              cs = hs;
        end
    end
endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
    import rtg_pkg::*;
(
    input  logic              clk,
    input  logic              clr,
    input  logic [MODE_W-1:0] mode_word,
    input  logic [CW-1:0]     h_total,
    input  logic [CW-1:0]     v_total,
    input  logic [CW-1:0]     half_line,
    input  logic [CW-1:0]     hs_start,
    input  logic [CW-1:0]     hs_end,
    input  logic [CW-1:0]     hb_start,
    input  logic [CW-1:0]     hb_end,
    input  logic [CW-1:0]     vs_start,
    input  logic [CW-1:0]     vs_end,
    input  logic [CW-1:0]     vb_start,
    input  logic [CW-1:0]     vb_end,
    input  logic [CW-1:0]     eq_start,
    input  logic [CW-1:0]     eq_end,
    input  logic [CW-1:0]     ser_start,
    input  logic [CW-1:0]     ser_end,
    input  logic [CW-1:0]     eqz_start,
    input  logic [CW-1:0]     eqz_end,
    output logic              hsync_o,
    output logic              hblank_o,
    output logic              vcsync_o,
    output logic              vcblank_o,
    output logic              odd_o
);
    localparam int unsigned NWIN = 4;
    localparam int unsigned W_HS = 0;
    localparam int unsigned W_HB = 1;
    localparam int unsigned W_VS = 2;
    localparam int unsigned W_VB = 3;

    rtg_state_t st_d, st_q;
    cnt_t       hcnt_n, vcnt_n;
    logic       odd_n;
    cnt_t       hcnt_q, vcnt_q;
    logic       cs_raw, cb_raw;

    cnt_t            win_cnt [NWIN];
    cnt_t            win_lo  [NWIN];
    cnt_t            win_hi  [NWIN];
    logic [NWIN-1:0] win_act;

    assign hcnt_q = st_q.hcnt;
    assign vcnt_q = st_q.vcnt;

    rtg_counters #(.W(CW)) u_cnt (
        .run      (mode_word[M_RUN]),
        .interlace(mode_word[M_ILACE]),
        .hcnt     (st_q.hcnt),
        .vcnt     (st_q.vcnt),
        .odd      (st_q.odd),
        .h_total  (h_total),
        .v_total  (v_total),
        .hcnt_n   (hcnt_n),
        .vcnt_n   (vcnt_n),
        .odd_n    (odd_n)
    );

    assign win_cnt[W_HS] = hcnt_n;  assign win_lo[W_HS] = hs_start;  assign win_hi[W_HS] = hs_end;
    assign win_cnt[W_HB] = hcnt_n;  assign win_lo[W_HB] = hb_start;  assign win_hi[W_HB] = hb_end;
    assign win_cnt[W_VS] = vcnt_n;  assign win_lo[W_VS] = vs_start;  assign win_hi[W_VS] = vs_end;
    assign win_cnt[W_VB] = vcnt_n;  assign win_lo[W_VB] = vb_start;  assign win_hi[W_VB] = vb_end;

    for (genvar g = 0; g < NWIN; g++) begin : g_win
        rtg_window #(.W(CW)) u_win (
            .cnt(win_cnt[g]),
            .lo (win_lo[g]),
            .hi (win_hi[g]),
            .act(win_act[g])
        );
    end

    rtg_compose #(.W(CW)) u_comp (
        .hcnt     (hcnt_n),
        .vcnt     (vcnt_n),
        .half     (half_line),
        .eq_lo    (eq_start),
        .eq_hi    (eq_end),
        .ser_lo   (ser_start),
        .ser_hi   (ser_end),
        .eqz_lo   (eqz_start),
        .eqz_hi   (eqz_end),
        .hs       (win_act[W_HS]),
        .hb       (win_act[W_HB]),
        .vs       (win_act[W_VS]),
        .vb       (win_act[W_VB]),
        .composite(mode_word[M_COMP]),
        .eq_en    (mode_word[M_EQ]),
        .cs       (cs_raw),
        .cb       (cb_raw)
    );

    always_comb begin
        st_d      = st_q;
        st_d.hcnt = hcnt_n;
        st_d.vcnt = vcnt_n;
        st_d.odd  = odd_n;
        st_d.hs   = win_act[W_HS] ^ mode_word[M_HSINV];
        st_d.hb   = win_act[W_HB] ^ mode_word[M_HBINV];
        st_d.vcs  = cs_raw ^ mode_word[M_CSINV];
        st_d.vcb  = cb_raw ^ mode_word[M_CBINV];
    end

    always_ff @(negedge clk or posedge clr) begin
        if (clr) begin
            st_q     <= '0;
            st_q.odd <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign hsync_o   = st_q.hs;
    assign hblank_o  = st_q.hb;
    assign vcsync_o  = st_q.vcs;
    assign vcblank_o = st_q.vcb;
    assign odd_o     = st_q.odd;
endmodule

// File: rtl/rtg_checker.sv
module rtg_checker
    import rtg_pkg::*;
(
    input logic              clk,
    input logic              clr,
    input logic [MODE_W-1:0] mode_word,
    input logic [CW-1:0]     h_total,
    input logic [CW-1:0]     v_total,
    input logic [CW-1:0]     hcnt,
    input logic [CW-1:0]     vcnt,
    input logic              odd
);
    localparam int unsigned XW = CW + 1;
    logic run, ilace, h_end, v_end;

    assign run   = mode_word[M_RUN];
    assign ilace = mode_word[M_ILACE];
    assign h_end = ({1'b0, hcnt} + XW'(1)) >= {1'b0, h_total};
    assign v_end = ({1'b0, vcnt} + XW'(1)) >= {1'b0, v_total};

    AST_HCNT_STEP: assert property (@(negedge clk) disable iff (clr)
        run && !h_end |=> hcnt == $past(hcnt) + CW'(1)); // R1
    AST_HCNT_WRAP: assert property (@(negedge clk) disable iff (clr)
        run && h_end |=> hcnt == '0); // R1
    AST_VCNT_WRAP: assert property (@(negedge clk) disable iff (clr)
        run && h_end && v_end |=> vcnt == '0); // R1
    AST_HOLD_STOPPED: assert property (@(negedge clk) disable iff (clr)
        !run |=> $stable(hcnt) && $stable(vcnt)); // R10
    AST_FIELD_FLIP: assert property (@(negedge clk) disable iff (clr)
        run && ilace && h_end && v_end |=> odd != $past(odd)); // R8
    AST_FIELD_HIGH: assert property (@(negedge clk) disable iff (clr)
        !ilace |=> odd); // R8
endmodule

bind raster_timing_gen rtg_checker u_rtg_checker (
    .clk      (clk),
    .clr      (clr),
    .mode_word(mode_word),
    .h_total  (h_total),
    .v_total  (v_total),
    .hcnt     (hcnt_q),
    .vcnt     (vcnt_q),
    .odd      (odd_o)
);

// File: tb/raster_timing_gen_bench.sv
module raster_timing_gen_bench;
    localparam int H = 20;
    localparam int V = 8;

    logic        clk = 1'b0;
    logic        clr = 1'b1;
    logic [7:0]  mode = 8'h00;
    logic [11:0] h_total = 12'(H), v_total = 12'(V), half_line = 12'd10;
    logic [11:0] hs_s = 12'd2,  hs_e = 12'd5;
    logic [11:0] hb_s = 12'd17, hb_e = 12'd3;
    logic [11:0] vs_s = 12'd3,  vs_e = 12'd5;
    logic [11:0] vb_s = 12'd6,  vb_e = 12'd1;
    logic [11:0] eq_s = 12'd2,  eq_e = 12'd3;
    logic [11:0] se_s = 12'd7,  se_e = 12'd9;
    logic [11:0] ez_s = 12'd2,  ez_e = 12'd6;
    logic hs_o, hb_o, vcs_o, vcb_o, odd_o;

    int tests = 0;
    int fails = 0;
    int pos   = 0;

    always #5 clk = ~clk;

    raster_timing_gen u_raster_timing_gen (
        .clk(clk), .clr(clr), .mode_word(mode),
        .h_total(h_total), .v_total(v_total), .half_line(half_line),
        .hs_start(hs_s), .hs_end(hs_e), .hb_start(hb_s), .hb_end(hb_e),
        .vs_start(vs_s), .vs_end(vs_e), .vb_start(vb_s), .vb_end(vb_e),
        .eq_start(eq_s), .eq_end(eq_e), .ser_start(se_s), .ser_end(se_e),
        .eqz_start(ez_s), .eqz_end(ez_e),
        .hsync_o(hs_o), .hblank_o(hb_o), .vcsync_o(vcs_o), .vcblank_o(vcb_o),
        .odd_o(odd_o)
    );

    function automatic logic win(input logic [11:0] c, input logic [11:0] lo, input logic [11:0] hi);
        if (lo <= hi) return (c >= lo) && (c < hi);
        return (c >= lo) || (c < hi);
    endfunction

    task automatic chk(input logic act, input logic exp, input string tag);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s pos=%0d actual=%b expected=%b", tag, pos, act, exp);
        end
    endtask

    task automatic check_pos(input string extra);
        logic [11:0] h, v;
        logic hs, hb, vs, vb, cs, cb, od;
        h  = 12'(pos % H);
        v  = 12'((pos / H) % V);
        hs = win(h, hs_s, hs_e);
        hb = win(h, hb_s, hb_e);
        vs = win(v, vs_s, vs_e);
        vb = win(v, vb_s, vb_e);
        if (!mode[1])     cs = vs;
        else if (!mode[3]) cs = hs ^ vs;
        else if (vs)      cs = !(win(h, se_s, se_e) || win(h, se_s + half_line, se_e + half_line));
        else if (win(v, ez_s, ez_e))
                          cs = win(h, eq_s, eq_e) || win(h, eq_s + half_line, eq_e + half_line);
        else              cs = hs;
        cb = mode[1] ? (hb | vb) : vb;
        od = mode[2] ? (((pos / (H * V)) % 2) == 0) : 1'b1;
        chk(hs_o,  hs ^ mode[4], {"R1 R2 R4 ", extra});
        chk(hb_o,  hb ^ mode[5], {"R2 R4 ", extra});
        chk(vcs_o, cs ^ mode[6], {mode[1] ? (mode[3] ? "R6 R7 R4 " : "R5 R4 ") : "R3 R4 ", extra});
        chk(vcb_o, cb ^ mode[7], {mode[1] ? "R5 R4 " : "R3 R4 ", extra});
        chk(odd_o, od, {"R8 ", extra});
    endtask

    task automatic run_edges(input int n, input string extra);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (mode[0]) pos++;
            @(posedge clk);
            check_pos(extra);
        end
    endtask

    task automatic clear_check();
        @(posedge clk); #1;
        clr = 1'b1; #2;
        chk(hs_o, 1'b0, "R9 hs"); chk(hb_o, 1'b0, "R9 hb");
        chk(vcs_o, 1'b0, "R9 vcs"); chk(vcb_o, 1'b0, "R9 vcb");
        chk(odd_o, 1'b1, "R9 odd");
        @(posedge clk); #1;
        clr = 1'b0;
        pos = 0;
    endtask

    task automatic config_run(input logic [7:0] m, input int n);
        clear_check();
        mode = m;
        run_edges(n, "");
    endtask

    initial begin
        #100000000;
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (2) @(posedge clk);
        clear_check();
        // R10: stopped after clear, position stays at the origin
        mode = 8'h30;
        run_edges(6, "R10");
        mode = 8'h01;
        run_edges(2 * H * V + 7, "");                   // separate, plain
        config_run(8'hF5, H * V + 13);                   // interlace, all inverted
        mode = 8'hF4;
        run_edges(6, "R10");                             // stop mid-frame
        mode = 8'hF5;
        run_edges(H * V + 20, "");
        config_run(8'h07, H * V + 30);                   // composite, no equalisation
        clear_check();                                   // R9 mid-run clear
        mode = 8'h07;
        run_edges(H * V + 5, "");
        config_run(8'h4B, 2 * H * V + 3);                // composite with eq/serration
        config_run(8'h0F, 2 * H * V + 3);                // same, interlaced
        hs_s = 12'd9; hs_e = 12'd9;                      // R2 empty window
        config_run(8'h09, H * V + 3);                    // R3 eq ignored in separate mode
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule